// File: doc/BRIEF.md
# Float Longword Convert Unit

This block converts a stream of 32-bit values between a sign-magnitude floating format and 32-bit two's-complement integers, one element per clock. Every element arrives with a 4-bit conversion code, an exception-enable bit and a destination register number. The result appears one clock later. For each element the block also reports on a per-element exception interface: the exception type bits and the destination register it belongs to.

The float word places its sign at bit 15 and an 8-bit exponent e at bits 14:7. The 23 stored fraction bits are split: the upper seven sit in bits 6:0 and the lower sixteen in bits 31:16. With a hidden leading fraction bit, the value is 0.1f × 2^(e−128). A word with e = 0 is zero when its sign is 0. It is a reserved operand when its sign is 1.

The block supports three conversions. Integer to float rounds to the nearest value, and ties go away from zero. Float to integer comes in two forms, one truncating and one rounding. Rounding adds half a unit to the magnitude before the sign is applied. An integer that is too large wraps to the low 32 bits of the exact result; it is never saturated.

Top module: `fl_cvt_unit`

## Requirements
- R1: While reset is asserted and right after it is released, outValid, excValid and outData are 0.
- R2: An element accepted with inValid high produces outValid high exactly one clock later, with its result on outData. A clock with inValid low produces outValid and excValid low one clock later. Elements may arrive on consecutive clocks.
- R3: Code 4'b0001 converts a two's-complement integer to the float format. The 24-bit significand is rounded to nearest with ties away from zero, and a rounding carry bumps the exponent. Zero gives an all-zero word. This code never raises an exception.
- R4: Code 4'b0100 converts a float to an integer, truncating toward zero.
- R5: Code 4'b0101 converts a float to an integer. It adds one half to the magnitude and then truncates, before negation, so -2.5 gives -3 and 0.5 gives 1.
- R6: When the exact integer does not fit in 32 bits, outData holds the low 32 bits of the exact two's-complement result, whatever the enable bit says.
- R7: Integer overflow with the enable bit set raises excValid with excType 4'b1000 (bit 3) and excDest equal to the element's destination register. With the enable bit clear, no exception is raised.
- R8: A reserved-operand source under code 4'b0100 or 4'b0101 gives outData 0 and raises excType 4'b0100 (bit 2) with its destination register, even when the enable bit is clear.
- R9: The float value exactly -2^31 (exponent 160, significand 0x800000, sign 1) converts to 32'h80000000 without an overflow exception.
- R10: Any other conversion code, 4'b0000 included, gives outData 0 and no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An element is presented this clock |
| convCode | input | 4 | Conversion selector |
| excEnable | input | 1 | Enables reporting of integer overflow |
| destReg | input | DEST_W | Destination register number of the element |
| srcData | input | 32 | Source element |
| outValid | output | 1 | Result valid |
| outData | output | 32 | Converted element |
| excValid | output | 1 | Exception reported for this result |
| excType | output | 4 | Exception type bits (bit 3 overflow, bit 2 reserved operand) |
| excDest | output | DEST_W | Destination register of the reported exception |

## Verification
The hardest cases to reach are at the edges of the integer range. One is the single float value that equals -2^31 exactly. The others are its positive twin and the neighbouring exponents, where a one-bit change in sign or significand decides between a clean result and an overflow. Integer-to-float inputs that carry out of the significand during rounding are equally narrow. Random words almost never land on any of these, so the stimulus builds such floats directly from sign, exponent and significand fields. It also steps through 0x7FFFFFFF and values just over 2^24. A reference built on a wide fixed-point shift then judges each result every clock, alongside a random stream.

// File: rtl/fl_cvt_pkg.sv
package fl_cvt_pkg;
  localparam int WORD_W    = 32;
  localparam int MANT_W    = 24;
  localparam int EXP_W     = 8;
  localparam int EXP_BIAS  = 128;
  localparam int INT_POINT = EXP_BIAS + MANT_W;           // exponent where significand is an integer
  localparam int OVF_EXP   = INT_POINT + WORD_W - MANT_W; // first exponent reaching 2^31
  localparam int TYPE_W    = 4;
  localparam int OVF_BIT   = 3;
  localparam int RSVD_BIT  = 2;

  localparam logic [3:0] CODE_I2F       = 4'b0001;
  localparam logic [3:0] CODE_F2I_TRUNC = 4'b0100;
  localparam logic [3:0] CODE_F2I_RND   = 4'b0101;

  localparam logic [MANT_W-1:0] MANT_MIN = MANT_W'(1) << (MANT_W - 1);

  typedef struct packed {
    logic take;
    logic intToFlt;
    logic fltToInt;
    logic roundOn;
  } cvtStrobe_t;

  typedef struct packed {
    logic ovf;
    logic rsvd;
  } cvtStatus_t;
endpackage

// File: rtl/fl_cvt_ctrl.sv
module fl_cvt_ctrl
  import fl_cvt_pkg::*;
#(
  parameter int DEST_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        convCode,
  input  logic              excEnable,
  input  logic [DEST_W-1:0] destReg,
  input  cvtStatus_t        status,
  output cvtStrobe_t        strobe,
  output logic              outValid,
  output logic              excValid,
  output logic [TYPE_W-1:0] excType,
  output logic [DEST_W-1:0] excDest
);
  logic              raise;
  logic [TYPE_W-1:0] typeNow;

  always_comb begin
    strobe.take     = inValid;
    strobe.intToFlt = inValid && (convCode == CODE_I2F);
    strobe.fltToInt = inValid && ((convCode == CODE_F2I_TRUNC) || (convCode == CODE_F2I_RND));
    strobe.roundOn  = (convCode == CODE_F2I_RND);
    typeNow              = '0;
    typeNow[OVF_BIT]     = status.ovf && excEnable;
    typeNow[RSVD_BIT]    = status.rsvd;
    raise                = |typeNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      excValid <= 1'b0;
      excType  <= '0;
      excDest  <= '0;
    end else begin
      outValid <= inValid;
      excValid <= raise;
      excType  <= typeNow;
      excDest  <= raise ? destReg : '0;
    end
  end
endmodule

// File: rtl/fl_cvt_datapath.sv
module fl_cvt_datapath
  import fl_cvt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cvtStrobe_t        strobe,
  input  logic [WORD_W-1:0] srcData,
  output cvtStatus_t        status,
  output logic [WORD_W-1:0] outData
);
  // float fields
  logic              fSign;
  logic [EXP_W-1:0]  fExp;
  logic [MANT_W-1:0] fMant;
  logic              fSpecial;
  // float to integer
  logic [8:0]        leftSh;
  logic [8:0]        rightSh;
  logic [MANT_W-1:0] halfMag;
  logic [WORD_W-1:0] f2iMag;
  logic [WORD_W-1:0] f2iRes;
  logic              f2iOvf;
  // integer to float
  logic              iNeg;
  logic [WORD_W-1:0] iMag;
  logic [4:0]        lead;
  logic [MANT_W:0]   halfT;
  logic [MANT_W-2:0] iFrac;
  logic [EXP_W-1:0]  iExp;
  logic [WORD_W-1:0] i2fRes;
  logic [WORD_W-1:0] resNow;

  always_comb begin
    fSign    = srcData[15];
    fExp     = srcData[14:7];
    fMant    = {1'b1, srcData[6:0], srcData[31:16]};
    fSpecial = (fExp == '0);
    leftSh   = '0;
    rightSh  = '0;
    halfMag  = '0;
    f2iMag   = '0;
    f2iOvf   = 1'b0;
    if (fExp >= EXP_W'(INT_POINT)) begin
      leftSh = 9'(fExp) - 9'(INT_POINT);
      if (leftSh < 9'(WORD_W)) f2iMag = {{(WORD_W-MANT_W){1'b0}}, fMant} << leftSh[4:0];
      f2iOvf = (fExp > EXP_W'(OVF_EXP)) ||
               ((fExp == EXP_W'(OVF_EXP)) && !(fSign && (fMant == MANT_MIN)));
    end else begin
      // keep one fraction bit, then add the rounding half and drop it
      rightSh = 9'(INT_POINT) - 9'(fExp) - 9'd1;
      if (rightSh < 9'(MANT_W)) halfMag = fMant >> rightSh;
      f2iMag = WORD_W'(((MANT_W+1)'(halfMag) + (MANT_W+1)'(strobe.roundOn)) >> 1);
    end
    f2iRes = fSign ? (~f2iMag + 1'b1) : f2iMag;
    if (fSpecial) begin
      f2iRes = '0;
      f2iOvf = 1'b0;
    end
    status.rsvd = strobe.fltToInt && fSpecial && fSign;
    status.ovf  = strobe.fltToInt && f2iOvf;
  end

  always_comb begin
    iNeg  = srcData[WORD_W-1];
    iMag  = iNeg ? (~srcData + 1'b1) : srcData;
    lead  = '0;
    for (int k = 0; k < WORD_W; k++) begin
      if (iMag[k]) lead = 5'(k);
    end
    halfT = '0;
    iExp  = EXP_W'(EXP_BIAS + 1) + EXP_W'(lead);
    if (lead <= 5'(MANT_W - 1)) begin
      iFrac = (MANT_W-1)'(iMag << (5'(MANT_W - 1) - lead));
    end else begin
      halfT = (MANT_W+1)'(iMag >> (lead - 5'(MANT_W)));
      if (&halfT) begin
        iFrac = '0;
        iExp  = iExp + 1'b1;
      end else begin
        iFrac = (MANT_W-1)'(((MANT_W+2)'(halfT) + 1'b1) >> 1);
      end
    end
    i2fRes = (iMag == '0) ? '0 : {iFrac[15:0], iNeg, iExp, iFrac[22:16]};
  end

  always_comb begin
    if (strobe.intToFlt)      resNow = i2fRes;
    else if (strobe.fltToInt) resNow = f2iRes;
    else                      resNow = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            outData <= '0;
    else if (strobe.take) outData <= resNow;
  end
endmodule

// File: rtl/fl_cvt_unit.sv
module fl_cvt_unit
  import fl_cvt_pkg::*;
#(
  parameter int DEST_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        convCode,
  input  logic              excEnable,
  input  logic [DEST_W-1:0] destReg,
  input  logic [31:0]       srcData,
  output logic              outValid,
  output logic [31:0]       outData,
  output logic              excValid,
  output logic [3:0]        excType,
  output logic [DEST_W-1:0] excDest
);
  cvtStrobe_t strobe;
  cvtStatus_t status;

  fl_cvt_ctrl #(.DEST_W(DEST_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .convCode(convCode),
    .excEnable(excEnable), .destReg(destReg), .status(status), .strobe(strobe),
    .outValid(outValid), .excValid(excValid), .excType(excType), .excDest(excDest)
  );

  fl_cvt_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcData(srcData),
    .status(status), .outData(outData)
  );
endmodule

// File: rtl/fl_cvt_unit_chk.sv
module fl_cvt_unit_chk #(
  parameter int DEST_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [3:0]        convCode,
  input logic              excEnable,
  input logic [DEST_W-1:0] destReg,
  input logic [31:0]       srcData,
  input logic              outValid,
  input logic [31:0]       outData,
  input logic              excValid,
  input logic [3:0]        excType,
  input logic [DEST_W-1:0] excDest
);
  logic isF2i;
  logic isKnown;
  logic srcRsvd;
  assign isF2i   = (convCode == 4'b0100) || (convCode == 4'b0101);
  assign isKnown = isF2i || (convCode == 4'b0001);
  assign srcRsvd = srcData[15] && (srcData[14:7] == 8'd0);

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !excValid));
  p_exc_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> ($countones(excType) == 1 && outValid));
  p_exc_dest_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isF2i && srcRsvd) |=> (excDest == $past(destReg)));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !excEnable && !srcRsvd) |=> !excValid);
  p_i2f_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && convCode == 4'b0001) |=> !excValid);
  p_rsvd_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isF2i && srcRsvd) |=> (excValid && excType == 4'b0100 && outData == 32'd0));
  p_bad_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isKnown) |=> (outData == 32'd0 && !excValid));
  always @(posedge clk) begin
    if (!rstN) begin
      a_reset_r1: assert (!outValid || $realtime == 0) else $error("outValid during reset");
    end
  end
endmodule

bind fl_cvt_unit fl_cvt_unit_chk #(.DEST_W(DEST_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .convCode(convCode),
  .excEnable(excEnable), .destReg(destReg), .srcData(srcData),
  .outValid(outValid), .outData(outData), .excValid(excValid),
  .excType(excType), .excDest(excDest)
);

// File: tb/fl_cvt_unit_bench.sv
`timescale 1ns/1ps
module fl_cvt_unit_bench;
  localparam int DEST_W = 4;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [3:0] convCode = '0;
  logic excEnable = 1'b0;
  logic [DEST_W-1:0] destReg = '0;
  logic [31:0] srcData = '0;
  logic outValid, excValid;
  logic [31:0] outData;
  logic [3:0] excType;
  logic [DEST_W-1:0] excDest;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // expectation for the element applied on the previous falling edge
  bit armed = 0;
  logic expV, expEV;
  logic [31:0] expD;
  logic [3:0] expT;
  logic [DEST_W-1:0] expDst;
  string expReq;

  always #2.5 clk = ~clk;

  fl_cvt_unit #(.DEST_W(DEST_W)) u_fl_cvt_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .convCode(convCode),
    .excEnable(excEnable), .destReg(destReg), .srcData(srcData),
    .outValid(outValid), .outData(outData), .excValid(excValid),
    .excType(excType), .excDest(excDest)
  );

  function automatic logic [31:0] mkF(input logic s, input int e, input logic [23:0] m);
    return {m[15:0], s, 8'(e), m[22:16]};
  endfunction

  // float to integer through a wide fixed-point value with 152 fraction bits
  task automatic refF2I(input logic [31:0] d, input bit rnd, output logic [31:0] r,
                        output bit ovf, output bit rsv);
    logic [279:0] full;
    logic [127:0] mag;
    int e;
    logic s;
    e = int'(d[14:7]);
    s = d[15];
    ovf = 0;
    rsv = (e == 0) && s;
    r = '0;
    if (e != 0) begin
      full = 280'({1'b1, d[6:0], d[31:16]}) << e;
      mag = full[279:152];
      if (rnd && full[151]) mag = mag + 1;
      ovf = s ? (mag > 128'h8000_0000) : (mag >= 128'h8000_0000);
      r = s ? (~mag[31:0] + 32'd1) : mag[31:0];
    end
  endtask

  function automatic logic [31:0] refI2F(input logic [31:0] d);
    longint mg;
    longint m;
    int bits;
    int e;
    logic s;
    s = d[31];
    mg = longint'($signed(d));
    if (mg < 0) mg = -mg;
    if (mg == 0) return 32'd0;
    bits = 0;
    while (mg >= (longint'(1) << bits)) bits++;
    e = 128 + bits;
    if (bits <= 24) m = mg << (24 - bits);
    else begin
      m = (mg + (longint'(1) << (bits - 25))) >> (bits - 24);
      if (m >= (longint'(1) << 24)) begin
        m = m >> 1;
        e++;
      end
    end
    return mkF(s, e, 24'(m));
  endfunction

  task automatic compare();
    bit bad;
    checks++;
    bad = (outValid !== expV);
    if (expV) begin
      if (outData !== expD || excValid !== expEV) bad = 1;
      if (expEV && (excType !== expT || excDest !== expDst)) bad = 1;
    end else if (excValid !== 1'b0) bad = 1;
    if (bad) begin
      fails++;
      $display("FAIL %s: actual v=%0b d=%h exc=%0b t=%b dst=%0d expected v=%0b d=%h exc=%0b t=%b dst=%0d",
               expReq, outValid, outData, excValid, excType, excDest,
               expV, expD, expEV, expT, expDst);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] code, input logic en,
                      input logic [DEST_W-1:0] dst, input logic [31:0] d, input string req);
    logic [31:0] r;
    bit ovf, rsv;
    @(negedge clk);
    if (armed) compare();
    inValid = v; convCode = code; excEnable = en; destReg = dst; srcData = d;
    expV = v; expEV = 0; expT = '0; expDst = '0; expD = '0; expReq = req;
    if (v) begin
      if (code == 4'b0001) expD = refI2F(d);
      else if (code == 4'b0100 || code == 4'b0101) begin
        refF2I(d, code == 4'b0101, r, ovf, rsv);
        expD = r;
        if (rsv) begin expEV = 1; expT = 4'b0100; expDst = dst; end
        else if (ovf && en) begin expEV = 1; expT = 4'b1000; expDst = dst; end
      end
    end
    armed = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || excValid !== 1'b0 || outData !== 32'd0) begin
      fails++;
      $display("FAIL R1: actual v=%0b exc=%0b d=%h expected 0 0 0", outValid, excValid, outData);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || excValid !== 1'b0 || outData !== 32'd0) begin
      fails++;
      $display("FAIL R1: actual v=%0b exc=%0b d=%h expected 0 0 0 after release", outValid, excValid, outData);
    end

    // R3 integer to float
    step(1, 4'b0001, 0, 1, 32'd0, "R3");
    step(1, 4'b0001, 0, 1, 32'd1, "R3");
    step(1, 4'b0001, 1, 1, 32'hFFFF_FFFF, "R3");
    step(1, 4'b0001, 0, 1, 32'd5, "R3");
    step(1, 4'b0001, 1, 2, 32'h7FFF_FFFF, "R3 carry");
    step(1, 4'b0001, 1, 2, 32'h8000_0000, "R3");
    step(1, 4'b0001, 0, 2, 32'h0100_0001, "R3 tie");
    step(1, 4'b0001, 0, 2, 32'h0100_0003, "R3");
    step(1, 4'b0001, 0, 2, 32'hFEFF_FFFF, "R3 neg tie");
    step(1, 4'b0001, 0, 2, 32'd12345678, "R3");
    step(0, 4'b0001, 0, 0, 32'd7, "R2 idle");
    // R4 truncation
    step(1, 4'b0100, 0, 3, mkF(0, 130, 24'hA00000), "R4 2.5");
    step(1, 4'b0100, 0, 3, mkF(1, 130, 24'hA00000), "R4 -2.5");
    step(1, 4'b0100, 0, 3, mkF(0, 128, 24'hC00000), "R4 0.75");
    step(1, 4'b0100, 0, 3, mkF(1, 159, 24'hFFFFFF), "R4 large");
    step(1, 4'b0100, 0, 3, mkF(0, 0, 24'h812345), "R4 zero");
    // R5 rounding on magnitude
    step(1, 4'b0101, 0, 4, mkF(0, 130, 24'hA00000), "R5 2.5");
    step(1, 4'b0101, 0, 4, mkF(1, 130, 24'hA00000), "R5 -2.5");
    step(1, 4'b0101, 0, 4, mkF(0, 128, 24'h800000), "R5 0.5");
    step(1, 4'b0101, 0, 4, mkF(1, 127, 24'hFFFFFF), "R5 below half");
    step(1, 4'b0101, 0, 4, mkF(1, 129, 24'hC00000), "R5 -1.5");
    // R9 boundary, R6/R7 overflow
    step(1, 4'b0100, 1, 5, mkF(1, 160, 24'h800000), "R9");
    step(1, 4'b0101, 1, 5, mkF(1, 160, 24'h800000), "R9");
    step(1, 4'b0100, 1, 6, mkF(0, 160, 24'h800000), "R7 pos 2^31");
    step(1, 4'b0100, 1, 6, mkF(1, 160, 24'h800001), "R7 neg");
    step(1, 4'b0100, 0, 6, mkF(0, 165, 24'hABCDEF), "R6 enable clear");
    step(1, 4'b0101, 1, 7, mkF(1, 170, 24'h923456), "R6 R7");
    step(1, 4'b0100, 1, 7, mkF(0, 255, 24'hFFFFFF), "R6 huge");
    // R8 reserved operand
    step(1, 4'b0100, 0, 8, mkF(1, 0, 24'h812345), "R8 enable clear");
    step(1, 4'b0101, 1, 9, mkF(1, 0, 24'hFFFFFF), "R8");
    // R10 unknown codes
    step(1, 4'b0000, 1, 10, mkF(0, 200, 24'h800000), "R10");
    step(1, 4'b0111, 1, 10, mkF(1, 0, 24'h800000), "R10");
    step(1, 4'b1111, 1, 10, 32'h1234_5678, "R10");
    step(0, 4'b0100, 1, 0, mkF(1, 0, 24'h800000), "R2 idle");
    // R2 random back-to-back stream
    for (int i = 0; i < 400; i++) begin
      logic [3:0] c;
      logic [31:0] d;
      int pick;
      pick = $urandom_range(0, 5);
      c = (pick < 2) ? 4'b0001 : (pick < 4) ? 4'b0100 : (pick == 4) ? 4'b0101 : 4'($urandom);
      d = $urandom;
      if (pick >= 2 && pick <= 4) d[14:7] = 8'($urandom_range(100, 175));
      step(($urandom_range(0, 7) != 0), c, 1'($urandom), DEST_W'($urandom), d, "R2 stream");
    end
    step(0, 4'b0000, 0, 0, 32'd0, "R2 flush");
    @(negedge clk);
    compare();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule